// File: doc/BRIEF.md
# Longitudinal Bang-Bang Bunch Damper

This block decides a three-level longitudinal kick for every bunch in a circulating ring. Once per turn each bunch delivers a signed phase sample, tagged with its bunch number. The block keeps a short history of past phases for every bunch. It passes that bunch's most recent samples through a programmable FIR filter whose default kernel estimates the rate of change of the phase. It then slices the filter result against an upper and a lower threshold.

A result above the upper threshold gives a positive kick and a result below the lower threshold gives a negative kick. Anything in between, the dead band, gives no kick. A turn marker counts turns from reset, and no kick leaves the block until every bunch can have a full history. An optional build variant also suppresses the kick for bunches whose intensity is below a programmable minimum.

Per-bunch history lives in a memory with one row per bunch. Each row holds the last TAPS phases. Every new sample is shifted in at the newest end and the oldest sample drops out. The read of a row and the write of its updated value happen on neighbouring cycles in a short pipeline. The same bunch must therefore not be presented in two consecutive cycles.

Top module: `bunch_kick_damper`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `kick_valid` is 0 and `kick_code` is 00.
- R2: A sample accepted with `in_valid` at a clock edge produces exactly one `kick_valid` pulse, visible after the second following edge. No `kick_valid` appears without a sample.
- R3: The filter for a sample uses only the phases of the same bunch index. Tap 0 is the new sample and tap k is that bunch's phase from k samples earlier. The new sample replaces the oldest one.
- R4: The filter result is y = sum over k of c[k]·x[k], computed in signed arithmetic of PH_W+CO_W+clog2(TAPS) bits.
- R5: If y > upper threshold the code is 01 (positive kick). If y < lower threshold the code is 11 (negative kick). Otherwise it is 00. A result equal to either threshold gives 00.
- R6: Until TAPS turn-marker pulses have been seen since reset, every output code is 00. The marker count is taken when the sample is accepted.
- R7: A configuration write to address k (0 ≤ k < TAPS) loads coefficient c[k] from the low CO_W data bits, as a signed value. After reset c[k] = +1 for k < TAPS/2 and −1 otherwise.
- R8: A write to address TAPS loads the upper threshold and a write to address TAPS+1 loads the lower threshold, each from the low accumulator-width data bits, signed. After reset they are +THR_DEF and −THR_DEF.
- R9: With GATE_EN = 1, a sample whose `in_inten` is below the unsigned minimum gives code 00. The minimum is written at address TAPS+2 and resets to 0. With GATE_EN = 0, `in_inten` has no effect.
- R10: Code 10 never appears, and `kick_code` is 00 whenever `kick_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Phase sample strobe |
| in_idx | input | IDX_W | Bunch number of the sample |
| in_phase | input | PH_W | Signed bunch phase |
| in_inten | input | INT_W | Unsigned bunch intensity (used with GATE_EN = 1) |
| turn_mark | input | 1 | One-cycle pulse at the start of each turn |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_AW | Configuration address |
| cfg_wdata | input | CFG_W | Configuration write data |
| kick_valid | output | 1 | Kick decision strobe |
| kick_code | output | 2 | 00 none, 01 positive, 11 negative |

## Verification
The bench builds the damper with five bunches, 12-bit phases and the intensity gate compiled in. The short turn lets the fill period, many full eight-turn histories and the default dead band be covered in a few thousand cycles. Compiling the gate in brings R9 within reach. Reprogramming the kernel to a single tap turns the filter into a pass-through. That puts the exact threshold boundaries of R5 under direct control, and random full-range coefficients, including −128, exercise the signed products of R4.

// File: rtl/dmp_pkg.sv
package dmp_pkg;
   typedef enum logic [1:0] {
      KICK_NONE = 2'b00,
      KICK_POS  = 2'b01,
      KICK_NEG  = 2'b11
   } kick_e;
endpackage

// File: rtl/dmp_hist_ram.sv
// One row per bunch; a row packs the last TAPS phases of that bunch.
module dmp_hist_ram #(
   parameter int NBUNCH = 588,
   parameter int IDX_W  = 10,
   parameter int ROW_W  = 112
) (
   input  logic             clk,
   input  logic             rd_en,
   input  logic [IDX_W-1:0] rd_addr,
   output logic [ROW_W-1:0] rd_row,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_addr,
   input  logic [ROW_W-1:0] wr_row
);
   logic [ROW_W-1:0] mem [NBUNCH];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_row;
      if (rd_en) rd_row <= mem[rd_addr];
   end
endmodule

// File: rtl/dmp_fir.sv
// Combinational weighted sum over one history row; tap 0 is the newest sample.
module dmp_fir #(
   parameter int TAPS  = 8,
   parameter int PH_W  = 14,
   parameter int CO_W  = 8,
   parameter int ACC_W = 25
) (
   input  logic        [TAPS*PH_W-1:0] row,
   input  logic signed [CO_W-1:0]      coef [TAPS],
   output logic signed [ACC_W-1:0]     y
);
   localparam int PW = PH_W + CO_W;

   logic signed [PW-1:0] prod [TAPS];

   for (genvar k = 0; k < TAPS; k++) begin : g_tap
      assign prod[k] = $signed(row[k*PH_W +: PH_W]) * coef[k];
   end

   always_comb begin
      y = '0;
      for (int k = 0; k < TAPS; k++)
         y = y + {{(ACC_W-PW){prod[k][PW-1]}}, prod[k]};
   end
endmodule

// File: rtl/dmp_slicer.sv
// Three-level decision with fill and optional intensity qualification.
module dmp_slicer import dmp_pkg::*; #(
   parameter int ACC_W   = 25,
   parameter int INT_W   = 12,
   parameter bit GATE_EN = 1'b0
) (
   input  logic signed [ACC_W-1:0] y,
   input  logic signed [ACC_W-1:0] thr_hi,
   input  logic signed [ACC_W-1:0] thr_lo,
   input  logic                    armed,
   input  logic [INT_W-1:0]        inten,
   input  logic [INT_W-1:0]        inten_min,
   output kick_e                   code
);
   logic pass;

   if (GATE_EN) begin : g_gate
      assign pass = (inten >= inten_min);
   end else begin : g_nogate
      logic unused_inten;
      assign unused_inten = ^{inten, inten_min};
      assign pass = 1'b1;
   end

   always_comb begin
      code = KICK_NONE;
      if (armed && pass) begin
         if (y > thr_hi)      code = KICK_POS;
         else if (y < thr_lo) code = KICK_NEG;
      end
   end
endmodule

// File: rtl/bunch_kick_damper.sv
module bunch_kick_damper import dmp_pkg::*; #(
   parameter int NBUNCH  = 588,
   parameter int IDX_W   = $clog2(NBUNCH),
   parameter int PH_W    = 14,
   parameter int TAPS    = 8,
   parameter int CO_W    = 8,
   parameter int INT_W   = 12,
   parameter bit GATE_EN = 1'b0,
   parameter int CFG_AW  = 4,
   parameter int CFG_W   = 32,
   parameter int THR_DEF = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [IDX_W-1:0]  in_idx,
   input  logic [PH_W-1:0]   in_phase,
   input  logic [INT_W-1:0]  in_inten,
   input  logic              turn_mark,
   input  logic              cfg_we,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [CFG_W-1:0]  cfg_wdata,
   output logic              kick_valid,
   output logic [1:0]        kick_code
);
   localparam int ROW_W = TAPS * PH_W;
   localparam int ACC_W = PH_W + CO_W + $clog2(TAPS);
   localparam int CNT_W = $clog2(TAPS + 1);

   initial begin
      assert (TAPS >= 2) else $error("TAPS must be at least 2");
      assert (IDX_W >= $clog2(NBUNCH)) else $error("IDX_W too narrow");
      assert (ACC_W <= CFG_W) else $error("CFG_W narrower than accumulator");
      assert (TAPS + 3 <= (1 << CFG_AW)) else $error("CFG_AW too narrow");
      assert (INT_W <= CFG_W && CO_W <= CFG_W) else $error("CFG_W too narrow");
   end

   // configuration registers
   logic signed [CO_W-1:0]  coef_q [TAPS];
   logic signed [ACC_W-1:0] thr_hi_q, thr_lo_q;
   logic [INT_W-1:0]        int_min_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < TAPS; k++)
            coef_q[k] <= (k < TAPS/2) ? {{(CO_W-1){1'b0}}, 1'b1} : {CO_W{1'b1}};
         thr_hi_q  <= ACC_W'(THR_DEF);
         thr_lo_q  <= ACC_W'(-THR_DEF);
         int_min_q <= '0;
      end else if (cfg_we) begin
         for (int k = 0; k < TAPS; k++)
            if (cfg_addr == CFG_AW'(k)) coef_q[k] <= cfg_wdata[CO_W-1:0];
         if (cfg_addr == CFG_AW'(TAPS))     thr_hi_q  <= cfg_wdata[ACC_W-1:0];
         if (cfg_addr == CFG_AW'(TAPS + 1)) thr_lo_q  <= cfg_wdata[ACC_W-1:0];
         if (cfg_addr == CFG_AW'(TAPS + 2)) int_min_q <= cfg_wdata[INT_W-1:0];
      end
   end

   if (ACC_W < CFG_W) begin : g_cfg_spare
      logic unused_cfg_hi;
      assign unused_cfg_hi = ^cfg_wdata[CFG_W-1:ACC_W];
   end

   // turn counter for the fill period
   logic [CNT_W-1:0] fill_cnt;
   logic             armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                       fill_cnt <= '0;
      else if (turn_mark && fill_cnt != CNT_W'(TAPS))   fill_cnt <= fill_cnt + 1'b1;
   end
   assign armed = (fill_cnt == CNT_W'(TAPS));

   // stage 1: row read
   logic             s1_v, s1_armed;
   logic [IDX_W-1:0] s1_idx;
   logic [PH_W-1:0]  s1_ph;
   logic [INT_W-1:0] s1_int;
   logic [ROW_W-1:0] rd_row, new_row;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_v <= 1'b0; s1_armed <= 1'b0; s1_idx <= '0; s1_ph <= '0; s1_int <= '0;
      end else begin
         s1_v <= in_valid;
         if (in_valid) begin
            s1_armed <= armed; s1_idx <= in_idx; s1_ph <= in_phase; s1_int <= in_inten;
         end
      end
   end

   dmp_hist_ram #(.NBUNCH(NBUNCH), .IDX_W(IDX_W), .ROW_W(ROW_W)) u_ram (
      .clk(clk), .rd_en(in_valid), .rd_addr(in_idx), .rd_row(rd_row),
      .wr_en(s1_v), .wr_addr(s1_idx), .wr_row(new_row));

   assign new_row = {rd_row[ROW_W-PH_W-1:0], s1_ph};

   // stage 2: filter result
   logic signed [ACC_W-1:0] y_c, s2_y;
   logic                    s2_v, s2_armed;
   logic [INT_W-1:0]        s2_int;

   dmp_fir #(.TAPS(TAPS), .PH_W(PH_W), .CO_W(CO_W), .ACC_W(ACC_W)) u_fir (
      .row(new_row), .coef(coef_q), .y(y_c));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s2_v <= 1'b0; s2_armed <= 1'b0; s2_y <= '0; s2_int <= '0;
      end else begin
         s2_v <= s1_v;
         if (s1_v) begin
            s2_armed <= s1_armed; s2_y <= y_c; s2_int <= s1_int;
         end
      end
   end

   // stage 3: decision
   kick_e code_c;

   dmp_slicer #(.ACC_W(ACC_W), .INT_W(INT_W), .GATE_EN(GATE_EN)) u_slice (
      .y(s2_y), .thr_hi(thr_hi_q), .thr_lo(thr_lo_q), .armed(s2_armed),
      .inten(s2_int), .inten_min(int_min_q), .code(code_c));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kick_valid <= 1'b0;
         kick_code  <= KICK_NONE;
      end else begin
         kick_valid <= s2_v;
         kick_code  <= s2_v ? code_c : KICK_NONE;
      end
   end
endmodule

// File: rtl/dmp_damper_chk.sv
module dmp_damper_chk #(
   parameter int TAPS = 8
) (
   input logic       clk,
   input logic       rst_n,
   input logic       in_valid,
   input logic       turn_mark,
   input logic       kick_valid,
   input logic [1:0] kick_code
);
   localparam int CW = $clog2(TAPS + 1);
   logic [CW-1:0] marks;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               marks <= '0;
      else if (turn_mark && marks != CW'(TAPS)) marks <= marks + 1'b1;
   end

   p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> ##3 kick_valid);
   p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |-> ##3 !kick_valid);
   p_quiet_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (kick_valid && $past(marks, 3) != CW'(TAPS)) |-> kick_code == 2'b00);
   p_legal_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
      kick_code != 2'b10);
   p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !kick_valid |-> kick_code == 2'b00);
endmodule

bind bunch_kick_damper dmp_damper_chk #(.TAPS(TAPS)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .turn_mark(turn_mark),
   .kick_valid(kick_valid), .kick_code(kick_code));

// File: tb/bunch_kick_damper_test.sv
module bunch_kick_damper_test;
   localparam int NB    = 5;
   localparam int IW    = 3;
   localparam int PW    = 12;
   localparam int TP    = 8;
   localparam int INTW  = 12;
   localparam int AW    = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic [IW-1:0] in_idx = '0;
   logic [PW-1:0] in_phase = '0;
   logic [INTW-1:0] in_inten = '0;
   logic turn_mark = 1'b0;
   logic cfg_we = 1'b0;
   logic [AW-1:0] cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic kick_valid;
   logic [1:0] kick_code;

   always #5 clk = ~clk;

   bunch_kick_damper #(.NBUNCH(NB), .IDX_W(IW), .PH_W(PW), .TAPS(TP), .CO_W(8),
      .INT_W(INTW), .GATE_EN(1'b1), .CFG_AW(AW), .CFG_W(32), .THR_DEF(16)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_idx(in_idx),
      .in_phase(in_phase), .in_inten(in_inten), .turn_mark(turn_mark),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .kick_valid(kick_valid), .kick_code(kick_code));

   int checks = 0, errors = 0;
   int hist [NB][TP];
   int cf [TP];
   int thr_hi = 16, thr_lo = -16, imin = 0, marks = 0;
   int slope [NB], base [NB];
   bit finished = 0;

   function automatic int rnd(int lo, int hi);
      return lo + int'($urandom % 32'(hi - lo + 1));
   endfunction

   function automatic logic [1:0] exp_code(int y, bit armed, int inten);
      if (!armed || inten < imin) return 2'b00;
      if (y > thr_hi) return 2'b01;
      if (y < thr_lo) return 2'b11;
      return 2'b00;
   endfunction

   task automatic check(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cfg_write(int addr, int data);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = AW'(addr); cfg_wdata = 32'(data);
      @(negedge clk);
      cfg_we = 1'b0;
      if (addr < TP) cf[addr] = int'($signed(8'(data)));
      else if (addr == TP) thr_hi = data;
      else if (addr == TP + 1) thr_lo = data;
      else imin = data & 12'hFFF;
   endtask

   task automatic mark();
      @(negedge clk); turn_mark = 1'b1;
      @(negedge clk); turn_mark = 1'b0;
      if (marks < TP) marks++;
   endtask

   // one sample; checks the strobe timing (R2) and the code (R3..R9)
   task automatic send(int b, int ph, int inten, string req);
      int y;
      logic [1:0] e;
      bit armed;
      armed = (marks >= TP);
      for (int k = TP - 1; k > 0; k--) hist[b][k] = hist[b][k-1];
      hist[b][0] = ph;
      y = 0;
      for (int k = 0; k < TP; k++) y += cf[k] * hist[b][k];
      e = exp_code(y, armed, inten);
      @(negedge clk);
      in_valid = 1'b1; in_idx = IW'(b); in_phase = PW'(ph); in_inten = INTW'(inten);
      @(negedge clk);
      in_valid = 1'b0;
      check(kick_valid == 1'b0, "R2 early strobe", int'(kick_valid), 0);
      @(negedge clk);
      check(kick_valid == 1'b0, "R2 early strobe", int'(kick_valid), 0);
      @(negedge clk);
      check(kick_valid == 1'b1, "R2 strobe", int'(kick_valid), 1);
      check(kick_code == e, req, int'(kick_code), int'(e));
      @(negedge clk);
      check(kick_valid == 1'b0 && kick_code == 2'b00, "R10 idle code", int'(kick_code), 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2718));
      for (int k = 0; k < TP; k++) cf[k] = (k < TP/2) ? 1 : -1;
      for (int b = 0; b < NB; b++) for (int k = 0; k < TP; k++) hist[b][k] = 0;

      // R1: reset state
      repeat (3) @(negedge clk);
      check(kick_valid == 0 && kick_code == 2'b00, "R1 in reset", int'(kick_code), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(kick_valid == 0 && kick_code == 2'b00, "R1 after reset", int'(kick_code), 0);

      // R3 R4 R5 R6 R7 R8: default kernel and thresholds, per-bunch ramps
      for (int b = 0; b < NB; b++) begin
         slope[b] = rnd(-5, 5);
         base[b]  = rnd(-400, 400);
      end
      slope[0] = 1; slope[1] = -3; slope[2] = 4;
      for (int t = 0; t < 14; t++) begin
         mark();
         for (int b = 0; b < NB; b++)
            send(b, base[b] + slope[b] * t + rnd(-1, 1), rnd(0, 4095),
                 (t < TP - 1) ? "R6 fill quiet" : "R3 R5 R7 R8 default decision");
      end

      // R5: exact threshold boundaries with a pass-through kernel
      cfg_write(0, 1);
      for (int k = 1; k < TP; k++) cfg_write(k, 0);
      cfg_write(TP, 100);
      cfg_write(TP + 1, -100);
      send(3, 100, 10, "R5 equal upper");
      send(3, 101, 10, "R5 above upper");
      send(3, -100, 10, "R5 equal lower");
      send(3, -101, 10, "R5 below lower");
      send(3, 0, 10, "R5 dead band");

      // R4 R7: oldest tap at the most negative coefficient
      cfg_write(0, 0);
      cfg_write(TP - 1, 8'h80);
      for (int t = 0; t < TP; t++)
         for (int b = 0; b < NB; b++) send(b, rnd(-3, 3), 100, "R4 negative extreme tap");

      // R4 R8 R9: random kernels, thresholds and intensity floor
      for (int r = 0; r < 4; r++) begin
         for (int k = 0; k < TP; k++) cfg_write(k, rnd(-128, 127));
         cfg_write(TP, rnd(0, 3000));
         cfg_write(TP + 1, -rnd(0, 3000));
         cfg_write(TP + 2, (r == 2) ? 2000 : 0);
         for (int t = 0; t < 4; t++) begin
            mark();
            for (int b = 0; b < NB; b++)
               send(b, rnd(-300, 300), rnd(0, 4095), "R4 R9 random kernel");
         end
      end

      // R9: intensity just below and at the floor, large derivative
      cfg_write(0, 1);
      for (int k = 1; k < TP; k++) cfg_write(k, 0);
      cfg_write(TP, 10);
      cfg_write(TP + 1, -10);
      cfg_write(TP + 2, 1500);
      send(4, 500, 1499, "R9 gated below floor");
      send(4, 500, 1500, "R9 at floor");
      send(4, -500, 0, "R9 gated below floor");

      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule